// File: doc/BRIEF.md
# Multi-State Linear Ramp Driver

This block turns a stream of digital logic symbols into two numeric drive values, one for the pull-down side and one for the pull-up side of an analog node. A table of up to twenty states holds, for each state, a pull-down target, a pull-up target and a switching time in clock cycles. Each of the six legal input symbols selects one table entry through a small remap table.

When the symbol changes, both outputs leave their present values in the same cycle and walk in straight lines toward the targets of the newly selected state. The walk takes the switching time of the destination state. A change that arrives while a walk is still running starts a fresh walk from wherever the outputs are at that moment. A busy flag marks a running walk. An error flag marks a symbol code outside the legal set.

Top module: `lin_ramp_drv`

## Requirements
- R1: In reset, drv_lo, drv_hi, busy and err are 0, and the held symbol is loaded from init_sym. While sym_in equals that held symbol afterwards, no walk starts and the outputs stay 0, whatever the table holds.
- R2: A legal sym_in that differs from the held symbol, sampled at edge k, becomes the held symbol. If the destination switching time D is non-zero, busy is 1 after edge k and both outputs still show their start values.
- R3: A walk lasts exactly D cycles, where D is the switching time of the destination state. After edge k+D both outputs equal the destination targets exactly and busy is 0.
- R4: After edge k+j, for 0 < j < D, each output equals floor((A*2^16 + j*S)/2^16). Here A is the start value and S = (T-A)*2^16/D, truncated toward zero, with T the target.
- R5: When the destination switching time is 0, both outputs equal the targets after edge k, and busy stays 0.
- R6: A legal change during a walk restarts the walk from the integer output values shown at that edge, toward the new targets, with the new state's D.
- R7: sym_in uses these codes: 0 for '0', 1 for '1', 2 for rise, 3 for fall, 4 for unknown, 5 for high-impedance. Each code selects the table entry given by its remap slot, and remap slot c resets to c.
- R8: Codes 6 and 7 are illegal. While one is present, err is 1 after each following edge. The held symbol and the outputs are left unchanged.
- R9: cfg_we with cfg_sel writes one field: 0 the pull-down target, 1 the pull-up target, 2 the switching time (low 12 bits), 3 the remap slot cfg_addr of a symbol. A table write with cfg_addr of 20 or more is ignored. A remap write with cfg_addr above 5 or cfg_data of 20 or more is ignored.
- R10: Presenting the held symbol again has no effect: no walk starts, and the outputs stay as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_sym | input | 3 | Symbol held from reset |
| sym_in | input | 3 | Input symbol code, sampled every cycle |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 2 | Field selector for the write |
| cfg_addr | input | 5 | Table index, or symbol code for remap writes |
| cfg_data | input | 16 | Write data |
| drv_lo | output | 16 | Pull-down drive value |
| drv_hi | output | 16 | Pull-up drive value |
| busy | output | 1 | A walk is in progress |
| err | output | 1 | Previous symbol code was illegal |

## Verification
The walk is driven with one output rising while the other rises, then with one falling while the other rises, so that a sign error in either channel's step shows up. A step that does not divide evenly shows whether truncation and the exact final load are right. A zero switching time separates the jump path from the walk path. A change halfway through a walk separates a restart from the live value from a restart from the last target. Repeated symbols and illegal codes show that state is left alone. A symbol remapped to index 19, next to a remap write with a rejected index, shows the remap path and its guard.

// File: rtl/lin_ramp_drv.sv
`timescale 1ns/1ps
module lin_ramp_drv #(
  parameter int NSTATE = 20,
  parameter int VAL_W  = 16,
  parameter int TIME_W = 12,
  parameter int FRAC_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                init_sym,
  input  logic [2:0]                sym_in,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_sel,
  input  logic [$clog2(NSTATE)-1:0] cfg_addr,
  input  logic [VAL_W-1:0]          cfg_data,
  output logic [VAL_W-1:0]          drv_lo,
  output logic [VAL_W-1:0]          drv_hi,
  output logic                      busy,
  output logic                      err
);
  localparam int AW   = $clog2(NSTATE);
  localparam int NSYM = 6;
  localparam int AV_W = VAL_W + FRAC_W;

  logic [VAL_W-1:0]  lo_tab [NSTATE];
  logic [VAL_W-1:0]  hi_tab [NSTATE];
  logic [TIME_W-1:0] tm_tab [NSTATE];
  logic [AW-1:0]     map_tab [NSYM];

  logic [2:0]        cur_sym;
  logic [AV_W-1:0]   acc_lo, acc_hi, step_lo, step_hi;
  logic [VAL_W-1:0]  tgt_lo, tgt_hi;
  logic [TIME_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTATE; i++) begin
        lo_tab[i] <= '0;
        hi_tab[i] <= '0;
        tm_tab[i] <= '0;
      end
      for (int c = 0; c < NSYM; c++) map_tab[c] <= AW'(c);
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: if (int'(cfg_addr) < NSTATE) lo_tab[cfg_addr] <= cfg_data;
        2'd1: if (int'(cfg_addr) < NSTATE) hi_tab[cfg_addr] <= cfg_data;
        2'd2: if (int'(cfg_addr) < NSTATE) tm_tab[cfg_addr] <= cfg_data[TIME_W-1:0];
        default:
          if (int'(cfg_addr) < NSYM && cfg_data < VAL_W'(NSTATE))
            map_tab[3'(cfg_addr)] <= cfg_data[AW-1:0];
      endcase
    end
  end

  logic              legal, change;
  logic [AW-1:0]     sel_idx;
  logic [VAL_W-1:0]  n_lo, n_hi;
  logic [TIME_W-1:0] n_tm;

  assign legal   = sym_in < 3'd6;
  assign change  = legal && (sym_in != cur_sym);
  assign sel_idx = legal ? map_tab[sym_in] : '0;
  assign n_lo    = lo_tab[sel_idx];
  assign n_hi    = hi_tab[sel_idx];
  assign n_tm    = tm_tab[sel_idx];

  function automatic logic [AV_W-1:0] step_of(input logic [VAL_W-1:0] from,
                                              input logic [VAL_W-1:0] to,
                                              input logic [TIME_W-1:0] dur);
    logic [VAL_W-1:0] mag;
    logic [AV_W-1:0]  q;
    mag = (to >= from) ? to - from : from - to;
    q = {mag, {FRAC_W{1'b0}}} / AV_W'((dur == '0) ? TIME_W'(1) : dur);
    return (to >= from) ? q : (~q + AV_W'(1));
  endfunction

  assign drv_lo = acc_lo[FRAC_W +: VAL_W];
  assign drv_hi = acc_hi[FRAC_W +: VAL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_sym <= init_sym;
      acc_lo  <= '0;
      acc_hi  <= '0;
      step_lo <= '0;
      step_hi <= '0;
      tgt_lo  <= '0;
      tgt_hi  <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      err     <= 1'b0;
    end else begin
      err <= !legal;
      if (change) begin
        cur_sym <= sym_in;
        tgt_lo  <= n_lo;
        tgt_hi  <= n_hi;
        step_lo <= step_of(drv_lo, n_lo, n_tm);
        step_hi <= step_of(drv_hi, n_hi, n_tm);
        cnt     <= n_tm;
        if (n_tm == '0) begin
          acc_lo <= {n_lo, {FRAC_W{1'b0}}};
          acc_hi <= {n_hi, {FRAC_W{1'b0}}};
          busy   <= 1'b0;
        end else begin
          acc_lo <= {drv_lo, {FRAC_W{1'b0}}};
          acc_hi <= {drv_hi, {FRAC_W{1'b0}}};
          busy   <= 1'b1;
        end
      end else if (busy) begin
        if (cnt == TIME_W'(1)) begin
          acc_lo <= {tgt_lo, {FRAC_W{1'b0}}};
          acc_hi <= {tgt_hi, {FRAC_W{1'b0}}};
          busy   <= 1'b0;
          cnt    <= '0;
        end else begin
          acc_lo <= acc_lo + step_lo;
          acc_hi <= acc_hi + step_hi;
          cnt    <= cnt - TIME_W'(1);
        end
      end
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    change && n_tm != '0 |=> busy && $stable(drv_lo) && $stable(drv_hi)); // R2
  AST_EXACT_END: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt == TIME_W'(1) && !change |=> !busy && drv_lo == $past(tgt_lo) && drv_hi == $past(tgt_hi)); // R3
  AST_ZERO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    change && n_tm == '0 |=> !busy && drv_lo == $past(n_lo) && drv_hi == $past(n_hi)); // R5
  AST_BAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> err); // R8
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !legal && !busy |=> !busy && $stable(drv_lo) && $stable(drv_hi)); // R8
  AST_SAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    legal && !change && !busy |=> !busy && $stable(drv_lo) && $stable(drv_hi)); // R10
endmodule

// File: tb/lin_ramp_drv_bench.sv
`timescale 1ns/1ps
module lin_ramp_drv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  init_sym = 3'd3;
  logic [2:0]  sym_in = 3'd3;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic [15:0] drv_lo, drv_hi;
  logic        busy, err;

  lin_ramp_drv u_lin_ramp_drv (
    .clk(clk), .rst_n(rst_n), .init_sym(init_sym), .sym_in(sym_in),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .drv_lo(drv_lo), .drv_hi(drv_hi), .busy(busy), .err(err));

  always #2.5 clk = ~clk;

  typedef struct {
    int    cyc;
    int    lo;
    int    hi;
    bit    bz;
    bit    er;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  int b_lo[20], b_hi[20], b_tm[20], b_map[6];
  int b_sym, cur_lo, cur_hi;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(exp_t x);
    checks++;
    if (int'(drv_lo) != x.lo || int'(drv_hi) != x.hi || busy != x.bz || err != x.er) begin
      errors++;
      $display("FAIL %s cyc %0d: lo=%0d hi=%0d busy=%0b err=%0b expected lo=%0d hi=%0d busy=%0b err=%0b",
               x.tag, x.cyc, drv_lo, drv_hi, busy, err, x.lo, x.hi, x.bz, x.er);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      if (e.cyc < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s: check for cyc %0d missed (actual cyc %0d, expected cyc %0d)", e.tag, e.cyc, cyc, e.cyc);
      end else compare(e);
    end
  end

  function automatic int ramp_val(int a, int t, int d, int j);
    longint s;
    if (d == 0 || j >= d) return t;
    s = (longint'(t - a) * 65536) / d;
    return int'((longint'(a) * 65536 + longint'(j) * s) >>> 16);
  endfunction

  task automatic push(int c, int lo, int hi, bit bz, bit er, string tag);
    exp_t x;
    x.cyc = c; x.lo = lo; x.hi = hi; x.bz = bz; x.er = er; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic cfg(int sel, int addr, int data);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = 5'(addr); cfg_data = 16'(data);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (sel < 3 && addr < 20) begin
      if (sel == 0) b_lo[addr] = data;
      else if (sel == 1) b_hi[addr] = data;
      else b_tm[addr] = data % 4096;
    end else if (sel == 3 && addr < 6 && data < 20) b_map[addr] = data;
  endtask

  task automatic apply(int s, int nobs, string tag);
    bit lg, chg;
    int idx, tl, th, d, nlo, nhi;
    lg = (s < 6);
    chg = lg && (s != b_sym);
    idx = 0; tl = 0; th = 0; d = 0;
    if (chg) begin
      idx = b_map[s]; tl = b_lo[idx]; th = b_hi[idx]; d = b_tm[idx];
    end
    sym_in = 3'(s);
    for (int j = 0; j < nobs; j++) begin
      if (chg) push(cyc + 1 + j, ramp_val(cur_lo, tl, d, j), ramp_val(cur_hi, th, d, j),
                    (d != 0 && j < d), !lg, tag);
      else push(cyc + 1 + j, cur_lo, cur_hi, 1'b0, !lg, tag);
    end
    repeat (nobs) @(posedge clk);
    #1;
    if (chg) begin
      nlo = ramp_val(cur_lo, tl, d, nobs - 1);
      nhi = ramp_val(cur_hi, th, d, nobs - 1);
      cur_lo = nlo; cur_hi = nhi; b_sym = s;
    end
  endtask

  initial begin
    for (int i = 0; i < 20; i++) begin b_lo[i] = 0; b_hi[i] = 0; b_tm[i] = 0; end
    for (int c = 0; c < 6; c++) b_map[c] = c;
    b_sym = 3; cur_lo = 0; cur_hi = 0;
    repeat (2) @(posedge clk);
    #1;
    push(cyc, 0, 0, 1'b0, 1'b0, "R1 in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    cfg(0, 0, 1000);  cfg(1, 0, 60000); cfg(2, 0, 0);
    cfg(0, 1, 50000); cfg(1, 1, 200);   cfg(2, 1, 8);
    cfg(0, 3, 7);     cfg(1, 3, 40000); cfg(2, 3, 5);
    cfg(0, 4, 333);   cfg(1, 4, 444);   cfg(2, 4, 0);
    cfg(0, 19, 12345); cfg(1, 19, 321); cfg(2, 19, 3);
    cfg(0, 25, 999);
    cfg(3, 5, 19);
    cfg(3, 4, 25);
    apply(3, 4, "R1 init symbol held");
    apply(1, 10, "R2 R3 R4 rising walk");
    apply(3, 7, "R3 R4 mixed-direction walk");
    apply(0, 2, "R5 zero-time jump");
    apply(1, 3, "R6 walk before restart");
    apply(3, 7, "R6 restart from live value");
    apply(3, 3, "R10 same symbol");
    apply(6, 2, "R8 illegal code 6");
    apply(7, 2, "R8 illegal code 7");
    apply(3, 2, "R8 R10 back to held symbol");
    apply(5, 5, "R7 remapped symbol to index 19");
    apply(4, 2, "R9 rejected remap write");
    apply(0, 2, "R5 jump after walk");
    while (q.size() > 0) @(posedge clk);
    @(posedge clk); #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung (actual cyc %0d, expected end before 20000)", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule